// File: doc/BRIEF.md
# Comparator Channel Output Conditioning and Interrupt

This block is the digital back end of a single analog comparator channel. The raw comparator decision arrives asynchronously. A chain of bus-clock flops resynchronizes it, and that sampled value appears as a read-only status bit. The output that goes on to other peripherals comes from one of two sources: the resynchronized sample or the raw signal unchanged. A gating enable then forces it low when the channel output is switched off.

The same sampled value feeds an interrupt source. The source can invert the value first. It then reacts either to the value's level or to a chosen transition: falling, rising, both, or none. Any hit sets a sticky flag, and software clears the flag by writing a one to it. The interrupt request is the flag qualified by a nonzero channel enable mode. The control register also holds the analog configuration fields: input selects, hysteresis and ladder settings. These fields are stored and read back, and they have no digital effect here.

The register port is a plain single-cycle write strobe with a combinational read. There is no data stream and no back-pressure. Every pin is control or status.

Top module: `cmp_chan_cond`

## Requirements
- R1: After reset the read value is 0. A write stores only the bits of mask 0x1F77F777. All other bits read 0, except bit 3 and bit 19, which are driven by the block.
- R2: Read bit 3 shows the comparator input after it has passed through SYNC_STAGES (default 2) bus clock flops. After a change of the input, the new value is visible once two rising edges have passed.
- R3: Output control uses bit 2 (output enable) and bit 12 (synchronize). When bit 2 is 0, `cmp_out` is 0. When bit 2 is 1 and bit 12 is 0, `cmp_out` follows `cmp_raw` directly. When bit 2 is 1 and bit 12 is 1, `cmp_out` follows the resynchronized sample.
- R4: Bit 15 = 1 inverts the sample before interrupt detection. Bit 15 = 0 uses the sample as it is.
- R5: With bit 16 = 0 the interrupt is edge triggered, and bits [18:17] select the edge of the polarity-adjusted sample: 0 = falling, 1 = rising, 2 = both, 3 = none.
- R6: With bit 16 = 1 the flag is set in every cycle in which the polarity-adjusted sample is high.
- R7: Bit 19 is a sticky flag. Writing 1 to bit 19 clears it. If a set event and a clear fall in the same cycle, the set wins.
- R8: `irq` is high exactly when the flag is set and bits [1:0] (enable mode) are nonzero.
- R9: In edge mode, a qualifying change of `cmp_raw` sets the flag at the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Raw analog comparator decision, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read value, including status and flag |
| cmp_out | output | 1 | Gated comparator output to other logic |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to produce from the ports is a clear write that lands in the same cycle as a set event. The stimulus creates it in level mode. It holds the polarity-adjusted sample high, so a set event occurs in every cycle, and then issues the write-one clear. The flag must still read 1 in the following cycle. The edge-mode latency is pinned the same way: the input is changed half a cycle before an edge, and the flag is sampled after the second and after the third rising edge.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int REG_W    = 32;
  localparam int EN_LSB   = 0;
  localparam int EN_W     = 2;
  localparam int OE_BIT   = 2;
  localparam int STAT_BIT = 3;
  localparam int SYNC_BIT = 12;
  localparam int INV_BIT  = 15;
  localparam int LVL_BIT  = 16;
  localparam int EDG_LSB  = 17;
  localparam int EDG_W    = 2;
  localparam int FLAG_BIT = 19;

  // Bits the register may hold at all (including status and flag positions)
  localparam logic [REG_W-1:0] HOLD_MASK = 32'h1F7F_F77F;
  // Bits actually stored in flops; status and flag are driven separately
  localparam logic [REG_W-1:0] STORE_MASK =
    HOLD_MASK & ~((REG_W'(1) << STAT_BIT) | (REG_W'(1) << FLAG_BIT));

  typedef enum logic [EDG_W-1:0] {
    EDG_FALL = 2'd0,
    EDG_RISE = 2'd1,
    EDG_BOTH = 2'd2,
    EDG_NONE = 2'd3
  } edge_pick_e;

  typedef struct packed {
    logic [EN_W-1:0] en_mode;
    logic            out_en;
    logic            sync_en;
    logic            inv;
    logic            lvl_mode;
    edge_pick_e      edge_pick;
  } chan_cfg_t;
endpackage

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output chan_cfg_t        cfg,
  output logic             flag_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & STORE_MASK;
  end

  assign flag_clr = wr_en & wr_data[FLAG_BIT];

  always_comb begin
    cfg.en_mode   = ctrl_q[EN_LSB +: EN_W];
    cfg.out_en    = ctrl_q[OE_BIT];
    cfg.sync_en   = ctrl_q[SYNC_BIT];
    cfg.inv       = ctrl_q[INV_BIT];
    cfg.lvl_mode  = ctrl_q[LVL_BIT];
    cfg.edge_pick = edge_pick_e'(ctrl_q[EDG_LSB +: EDG_W]);
  end
endmodule

// File: rtl/cmp_sync_chain.sv
module cmp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 1) begin : g_pass
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else begin
          sh[0] <= d;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cmp_irq_gen.sv
module cmp_irq_gen
  import cmp_cond_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp,
  input  logic            inv,
  input  logic            lvl_mode,
  input  edge_pick_e      edge_pick,
  input  logic [EN_W-1:0] en_mode,
  input  logic            flag_clr,
  output logic            flag_q,
  output logic            irq
);
  logic prev_q;
  logic pol_now, pol_prev, rise, fall, edge_hit, set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= samp;
  end

  // Both samples see the same inversion, so toggling inv alone makes no edge
  assign pol_now  = samp ^ inv;
  assign pol_prev = prev_q ^ inv;
  assign rise     = pol_now & ~pol_prev;
  assign fall     = ~pol_now & pol_prev;

  always_comb begin
    unique case (edge_pick)
      EDG_FALL: edge_hit = fall;
      EDG_RISE: edge_hit = rise;
      EDG_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  end

  assign set_evt = lvl_mode ? pol_now : edge_hit;

  // Set takes priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_evt | (flag_q & ~flag_clr);
  end

  assign irq = flag_q & (|en_mode);
endmodule

// File: rtl/cmp_chan_cond.sv
module cmp_chan_cond
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             cmp_out,
  output logic             irq
);
  logic [REG_W-1:0] ctrl_q;
  chan_cfg_t        cfg;
  logic             flag_clr, samp, flag_q;

  cmp_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .cfg(cfg), .flag_clr(flag_clr)
  );

  cmp_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(samp)
  );

  cmp_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .samp(samp), .inv(cfg.inv),
    .lvl_mode(cfg.lvl_mode), .edge_pick(cfg.edge_pick),
    .en_mode(cfg.en_mode), .flag_clr(flag_clr),
    .flag_q(flag_q), .irq(irq)
  );

  assign cmp_out = cfg.out_en & (cfg.sync_en ? samp : cmp_raw);

  always_comb begin
    rd_data           = ctrl_q;
    rd_data[STAT_BIT] = samp;
    rd_data[FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/cmp_chan_cond_chk.sv
module cmp_chan_cond_chk
  import cmp_cond_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             clr_req,
  input logic [REG_W-1:0] rd_data,
  input logic             cmp_out,
  input logic             irq
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~HOLD_MASK) == '0);

  // R3
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[OE_BIT] |-> !cmp_out);

  // R8
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[FLAG_BIT] && rd_data[EN_LSB +: EN_W] != '0));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[FLAG_BIT] && !clr_req) |=> rd_data[FLAG_BIT]);

  // R6
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[LVL_BIT] && (rd_data[STAT_BIT] ^ rd_data[INV_BIT]) && !wr_en)
      |=> rd_data[FLAG_BIT]);
endmodule

bind cmp_chan_cond cmp_chan_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .clr_req(wr_en && wr_data[cmp_cond_pkg::FLAG_BIT]),
  .rd_data(rd_data), .cmp_out(cmp_out), .irq(irq)
);

// File: tb/cmp_chan_cond_tb.sv
module cmp_chan_cond_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_raw = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cmp_out, irq;
  int checks = 0, failures = 0;

  localparam logic [31:0] CLR = 32'h0008_0000;

  cmp_chan_cond u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cmp_out(cmp_out), .irq(irq)
  );

  always #4 clk = ~clk;

  // {config, raw before, raw after, expected flag}
  localparam logic [34:0] VEC [14] = '{
    {32'h0000_0001, 1'b1, 1'b0, 1'b1},  // R5 falling hit
    {32'h0000_0001, 1'b0, 1'b1, 1'b0},  // R5 falling miss
    {32'h0002_0001, 1'b0, 1'b1, 1'b1},  // R5 rising hit
    {32'h0002_0001, 1'b1, 1'b0, 1'b0},  // R5 rising miss
    {32'h0004_0001, 1'b0, 1'b1, 1'b1},  // R5 both, up
    {32'h0004_0001, 1'b1, 1'b0, 1'b1},  // R5 both, down
    {32'h0006_0001, 1'b0, 1'b1, 1'b0},  // R5 code 3, up
    {32'h0006_0001, 1'b1, 1'b0, 1'b0},  // R5 code 3, down
    {32'h0002_8001, 1'b1, 1'b0, 1'b1},  // R4 inverted rising
    {32'h0002_8001, 1'b0, 1'b1, 1'b0},  // R4 inverted rising miss
    {32'h0001_0001, 1'b0, 1'b0, 1'b0},  // R6 level low
    {32'h0001_0001, 1'b0, 1'b1, 1'b1},  // R6 level high
    {32'h0001_8001, 1'b1, 1'b1, 1'b0},  // R4 level inverted low
    {32'h0001_8001, 1'b1, 1'b0, 1'b1}   // R4 level inverted high
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1 reset rd", rd_data, 32'h0);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    cyc(2);

    foreach (VEC[k]) begin
      cmp_raw = VEC[k][2];
      wr(VEC[k][34:3]);
      cyc(4);
      wr(VEC[k][34:3] | CLR);
      cyc(1);
      cmp_raw = VEC[k][1];
      cyc(4);
      chk("R5/R6/R4 flag", {31'b0, rd_data[19]}, {31'b0, VEC[k][0]});
      chk("R8 irq", {31'b0, irq}, {31'b0, VEC[k][0]});
    end

    // R1 stored field mask
    cmp_raw = 1'b0;
    wr(32'hFFFF_FFFF);
    chk("R1 mask", rd_data & 32'hFFF7_FFF7, 32'h1F77_F777);
    wr(32'h0000_0000 | CLR);
    cyc(4);
    wr(CLR);

    // R2 status latency
    cmp_raw = 1'b1;
    cyc(1);
    chk("R2 status early", {31'b0, rd_data[3]}, 32'h0);
    cyc(1);
    chk("R2 status", {31'b0, rd_data[3]}, 32'h1);

    // R3 direct, gated, synchronized output
    wr(32'h0000_0005);
    cmp_raw = 1'b0; #1;
    chk("R3 direct low", {31'b0, cmp_out}, 32'h0);
    cmp_raw = 1'b1; #1;
    chk("R3 direct high", {31'b0, cmp_out}, 32'h1);
    wr(32'h0000_0001);
    chk("R3 gated", {31'b0, cmp_out}, 32'h0);
    cmp_raw = 1'b0;
    wr(32'h0000_1005);
    cyc(3);
    cmp_raw = 1'b1; #1;
    chk("R3 sync hold", {31'b0, cmp_out}, 32'h0);
    cyc(1);
    chk("R3 sync one edge", {31'b0, cmp_out}, 32'h0);
    cyc(1);
    chk("R3 sync two edges", {31'b0, cmp_out}, 32'h1);

    // R9 edge latency
    cmp_raw = 1'b0;
    wr(32'h0002_0001);
    cyc(4);
    wr(32'h0002_0001 | CLR);
    cyc(1);
    cmp_raw = 1'b1;
    cyc(2);
    chk("R9 not yet", {31'b0, rd_data[19]}, 32'h0);
    cyc(1);
    chk("R9 set", {31'b0, rd_data[19]}, 32'h1);

    // R7 clear works in edge mode
    wr(32'h0002_0001 | CLR);
    chk("R7 clear", {31'b0, rd_data[19]}, 32'h0);

    // R7 set beats clear in level mode
    wr(32'h0001_0001);
    cyc(3);
    wr(32'h0001_0001 | CLR);
    chk("R7 set wins", {31'b0, rd_data[19]}, 32'h1);

    // R8 enable mode zero masks irq
    wr(32'h0001_0000);
    chk("R8 flag kept", {31'b0, rd_data[19]}, 32'h1);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule